// File: doc/BRIEF.md
# Outstanding Miss Request Merger

This block keeps a small file of outstanding memory requests, one entry per naturally aligned 64-byte block. Each incoming request brings a byte address and a kind code. The block compares the request against every live entry in parallel. If an entry covers the same 64-byte block and its kind accepts the new kind, the request joins that entry. Otherwise the request takes a fresh entry. The rule for which kinds may join is deliberately one-sided: an entry that began as a store also takes loads, but an entry that began as a load does not take stores.

A completion port names an entry that has finished and frees it. A completion and a request may arrive in the same cycle. The entry being freed is then no longer a merge target, but its slot may be handed to the request in that same cycle. For every accepted request the block reports, combinationally in the accepting cycle, the entry used, whether it merged or allocated, and how many requests that entry now represents. Requests that cannot be placed are held off by dropping ready.

Top module: `maf_merger`

## Requirements
- R1: After reset no entry is live. The first request allocates entry 0, with acc_merged low and acc_count equal to 1.
- R2: A request merges only into an entry whose address bits above bit 5 equal its own. Bits 5:0 play no part, and a different 64-byte block never merges.
- R3: An entry that was opened by a load (kind code 0) accepts only loads (code 0). A store (code 1) to that block opens a new entry.
- R4: An entry that was opened by a store (code 1) accepts both stores (code 1) and loads (code 0). Its kind stays store, so a later store still merges after a load has joined.
- R5: Entries opened by conditional store (code 2), write-hint-64 (code 3), evict-block (code 4) or instruction fetch (code 5) accept only a request of their own code. Any other pair of kinds never merges, even when the block matches. Codes 6 and 7 are reserved and are never accepted (req_ready stays low).
- R6: A request that cannot merge takes the lowest-numbered free entry.
- R7: When no entry can take the request and no entry is free, req_ready is low and nothing is accepted. A request that can merge is still accepted while the file is full.
- R8: A completion with index k frees entry k. A later request to that block opens a new entry rather than merging.
- R9: When a completion and a request arrive in the same cycle, the entry being completed is not a merge target, and its slot counts as free for that request.
- R10: acc_count reports the number of requests the entry holds after acceptance. With CNT_W=3 an entry holds at most 7. A full entry refuses further merges, so the next matching request allocates or stalls.
- R11: When several entries could take a request, the lowest-numbered one is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_addr | input | ADDR_W | Byte address of the request |
| req_kind | input | 3 | Kind code: 0 load, 1 store, 2 cond. store, 3 write-hint-64, 4 evict-block, 5 instruction fetch |
| req_ready | output | 1 | The request can be accepted this cycle |
| cpl_valid | input | 1 | An entry has completed |
| cpl_idx | input | IDX_W | Index of the completed entry |
| acc_valid | output | 1 | A request was accepted this cycle |
| acc_idx | output | IDX_W | Entry used by the accepted request |
| acc_merged | output | 1 | 1 if the request joined an existing entry, 0 if it allocated one |
| acc_count | output | CNT_W | Requests held by that entry after this one |

## Verification
Some properties are checked on every cycle. A merge always lands on a live entry that is not being completed in that cycle. An allocation always lands on a free or just-freed slot, and that slot is live on the next cycle. A completion clears its entry. Ready is high whenever the file has room and the kind is legal. Counts are 1 for a new entry and at least 2 for a merge. Other behaviour can only be shown by the bench's directed sequences: the one-sided kind matrix, choosing the lowest index among several candidates, count saturation forcing a new entry, and a slot being reused in the same cycle it is freed.

// File: rtl/maf_pkg.sv
package maf_pkg;

   localparam int MAF_BLK_OFS = 6;

   typedef enum logic [2:0] {
      KIND_LOAD   = 3'd0,
      KIND_STORE  = 3'd1,
      KIND_STCOND = 3'd2,
      KIND_WHINT  = 3'd3,
      KIND_EVICT  = 3'd4,
      KIND_IFETCH = 3'd5
   } maf_kind_e;

   function automatic logic maf_kind_legal(input logic [2:0] k);
      return k <= 3'd5;
   endfunction

   // held: kind stored in entry, incoming: kind of new request
   function automatic logic maf_compat(input logic [2:0] held, input logic [2:0] incoming);
      logic ok;
      ok = 1'b0;
      if (maf_kind_legal(incoming) && maf_kind_legal(held)) begin
         if (held == incoming)
            ok = 1'b1;
         else if (held == KIND_STORE && incoming == KIND_LOAD)
            ok = 1'b1;
      end
      return ok;
   endfunction

endpackage

// File: rtl/maf_pick_lowest.sv
module maf_pick_lowest #(
   parameter int WIDTH = 8,
   localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/maf_match.sv
module maf_match import maf_pkg::*; #(
   parameter int N_ENTRIES = 8,
   parameter int BLK_W     = 26,
   parameter int CNT_W     = 3
) (
   input  logic [N_ENTRIES-1:0]            live,
   input  logic [N_ENTRIES-1:0][BLK_W-1:0] ent_blk,
   input  logic [N_ENTRIES-1:0][2:0]       ent_kind,
   input  logic [N_ENTRIES-1:0][CNT_W-1:0] ent_cnt,
   input  logic [BLK_W-1:0]                req_blk,
   input  logic [2:0]                      req_kind,
   output logic [N_ENTRIES-1:0]            hit
);

   localparam logic [CNT_W-1:0] CNT_FULL = '1;

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
      logic same_blk;
      logic kind_ok;
      logic has_room;
      assign same_blk = (ent_blk[i] == req_blk);
      assign kind_ok  = maf_compat(ent_kind[i], req_kind);
      assign has_room = (ent_cnt[i] != CNT_FULL);
      assign hit[i]   = live[i] & same_blk & kind_ok & has_room;
   end

endmodule

// File: rtl/maf_entry_file.sv
module maf_entry_file #(
   parameter int N_ENTRIES = 8,
   parameter int BLK_W     = 26,
   parameter int CNT_W     = 3,
   localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            alloc_en,
   input  logic [IDX_W-1:0]                alloc_idx,
   input  logic [BLK_W-1:0]                alloc_blk,
   input  logic [2:0]                      alloc_kind,
   input  logic                            merge_en,
   input  logic [IDX_W-1:0]                merge_idx,
   input  logic                            clr_en,
   input  logic [IDX_W-1:0]                clr_idx,
   output logic [N_ENTRIES-1:0]            valid_q,
   output logic [N_ENTRIES-1:0][BLK_W-1:0] blk_q,
   output logic [N_ENTRIES-1:0][2:0]       kind_q,
   output logic [N_ENTRIES-1:0][CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      logic do_alloc;
      logic do_merge;
      logic do_clr;
      assign do_alloc = alloc_en && (alloc_idx == IDX_W'(i));
      assign do_merge = merge_en && (merge_idx == IDX_W'(i));
      assign do_clr   = clr_en   && (clr_idx   == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[i] <= 1'b0;
            blk_q[i]   <= '0;
            kind_q[i]  <= '0;
            cnt_q[i]   <= '0;
         end else if (do_alloc) begin
            // allocation wins over a completion of the same slot
            valid_q[i] <= 1'b1;
            blk_q[i]   <= alloc_blk;
            kind_q[i]  <= alloc_kind;
            cnt_q[i]   <= CNT_ONE;
         end else begin
            if (do_clr)
               valid_q[i] <= 1'b0;
            if (do_merge)
               cnt_q[i] <= cnt_q[i] + CNT_ONE;
         end
      end
   end

endmodule

// File: rtl/maf_merger.sv
module maf_merger import maf_pkg::*; #(
   parameter int N_ENTRIES = 8,
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 3,
   localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_kind,
   output logic              req_ready,
   input  logic              cpl_valid,
   input  logic [IDX_W-1:0]  cpl_idx,
   output logic              acc_valid,
   output logic [IDX_W-1:0]  acc_idx,
   output logic              acc_merged,
   output logic [CNT_W-1:0]  acc_count
);

   localparam int BLK_W = ADDR_W - MAF_BLK_OFS;

   if (N_ENTRIES < 2) begin : g_bad_depth
      $error("maf_merger: N_ENTRIES must be at least 2");
   end
   if (ADDR_W <= MAF_BLK_OFS) begin : g_bad_addr
      $error("maf_merger: ADDR_W must exceed the block offset width");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("maf_merger: CNT_W must be at least 2");
   end

   logic [N_ENTRIES-1:0]            valid_q;
   logic [N_ENTRIES-1:0][BLK_W-1:0] blk_q;
   logic [N_ENTRIES-1:0][2:0]       kind_q;
   logic [N_ENTRIES-1:0][CNT_W-1:0] cnt_q;

   logic [N_ENTRIES-1:0] cpl_vec;
   logic [N_ENTRIES-1:0] live;
   logic [N_ENTRIES-1:0] hit_vec;
   logic [N_ENTRIES-1:0] free_vec;
   logic                 hit_any;
   logic                 free_any;
   logic [IDX_W-1:0]     hit_idx;
   logic [IDX_W-1:0]     free_idx;
   logic [BLK_W-1:0]     req_blk;

   assign req_blk = req_addr[ADDR_W-1:MAF_BLK_OFS];

   always_comb begin
      cpl_vec = '0;
      if (cpl_valid)
         cpl_vec[cpl_idx] = 1'b1;
   end

   // an entry completing this cycle neither merges nor blocks allocation
   assign live     = valid_q & ~cpl_vec;
   assign free_vec = ~live;

   maf_match #(
      .N_ENTRIES(N_ENTRIES),
      .BLK_W    (BLK_W),
      .CNT_W    (CNT_W)
   ) u_match (
      .live    (live),
      .ent_blk (blk_q),
      .ent_kind(kind_q),
      .ent_cnt (cnt_q),
      .req_blk (req_blk),
      .req_kind(req_kind),
      .hit     (hit_vec)
   );

   maf_pick_lowest #(.WIDTH(N_ENTRIES)) u_pick_hit (
      .vec  (hit_vec),
      .found(hit_any),
      .idx  (hit_idx)
   );

   maf_pick_lowest #(.WIDTH(N_ENTRIES)) u_pick_free (
      .vec  (free_vec),
      .found(free_any),
      .idx  (free_idx)
   );

   assign req_ready  = maf_kind_legal(req_kind) && (hit_any || free_any);
   assign acc_valid  = req_valid && req_ready;
   assign acc_merged = hit_any;
   assign acc_idx    = hit_any ? hit_idx : free_idx;
   assign acc_count  = hit_any ? (cnt_q[hit_idx] + CNT_W'(1)) : CNT_W'(1);

   maf_entry_file #(
      .N_ENTRIES(N_ENTRIES),
      .BLK_W    (BLK_W),
      .CNT_W    (CNT_W)
   ) u_file (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (acc_valid && !hit_any),
      .alloc_idx (free_idx),
      .alloc_blk (req_blk),
      .alloc_kind(req_kind),
      .merge_en  (acc_valid && hit_any),
      .merge_idx (hit_idx),
      .clr_en    (cpl_valid),
      .clr_idx   (cpl_idx),
      .valid_q   (valid_q),
      .blk_q     (blk_q),
      .kind_q    (kind_q),
      .cnt_q     (cnt_q)
   );

endmodule

// File: rtl/maf_merger_chk.sv
module maf_merger_chk #(
   parameter int N_ENTRIES = 8,
   parameter int CNT_W     = 3,
   localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [2:0]           req_kind,
   input logic                 req_ready,
   input logic                 cpl_valid,
   input logic [IDX_W-1:0]     cpl_idx,
   input logic                 acc_valid,
   input logic [IDX_W-1:0]     acc_idx,
   input logic                 acc_merged,
   input logic [CNT_W-1:0]     acc_count,
   input logic [N_ENTRIES-1:0] valid_q
);

   // R1: a fresh entry starts with one request
   a_r1_new_count_one: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_merged) |-> (acc_count == CNT_W'(1)));

   // R10: a merged entry holds at least two requests
   a_r10_merge_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_merged) |-> (acc_count >= CNT_W'(2)));

   // R2: merge target is a live entry
   a_r2_merge_into_live: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_merged) |-> valid_q[acc_idx]);

   // R9: never merge into the entry completing now
   a_r9_no_merge_into_completing: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_merged && cpl_valid) |-> (acc_idx != cpl_idx));

   // R6: allocation uses a free or just-freed slot
   a_r6_alloc_into_free: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_merged) |-> (!valid_q[acc_idx] || (cpl_valid && cpl_idx == acc_idx)));

   // R6: the allocated slot is live afterwards
   a_r6_alloc_becomes_live: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_merged) |=> valid_q[$past(acc_idx)]);

   // R8: completion clears the entry unless reallocated in the same cycle
   a_r8_cpl_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !(acc_valid && !acc_merged && acc_idx == cpl_idx)) |=> !valid_q[$past(cpl_idx)]);

   // R7: with room in the file a legal request is never held off
   a_r7_ready_with_room: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind <= 3'd5 && $countones(valid_q) < N_ENTRIES) |-> req_ready);

endmodule

bind maf_merger maf_merger_chk #(
   .N_ENTRIES(N_ENTRIES),
   .CNT_W    (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_kind  (req_kind),
   .req_ready (req_ready),
   .cpl_valid (cpl_valid),
   .cpl_idx   (cpl_idx),
   .acc_valid (acc_valid),
   .acc_idx   (acc_idx),
   .acc_merged(acc_merged),
   .acc_count (acc_count),
   .valid_q   (valid_q)
);

// File: tb/maf_merger_tb.sv
module maf_merger_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N_ENTRIES  = 8;
   localparam int ADDR_W     = 32;
   localparam int CNT_W      = 3;
   localparam int IDX_W      = $clog2(N_ENTRIES);

   localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_STC = 3'd2,
                          K_WH = 3'd3, K_EV = 3'd4, K_IF = 3'd5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [2:0]        req_kind = '0;
   logic              req_ready;
   logic              cpl_valid = 1'b0;
   logic [IDX_W-1:0]  cpl_idx = '0;
   logic              acc_valid;
   logic [IDX_W-1:0]  acc_idx;
   logic              acc_merged;
   logic [CNT_W-1:0]  acc_count;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   typedef struct {
      int    idx;
      bit    merged;
      int    cnt;
      string tag;
   } exp_t;

   exp_t sb_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   maf_merger #(
      .N_ENTRIES(N_ENTRIES),
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_kind  (req_kind),
      .req_ready (req_ready),
      .cpl_valid (cpl_valid),
      .cpl_idx   (cpl_idx),
      .acc_valid (acc_valid),
      .acc_idx   (acc_idx),
      .acc_merged(acc_merged),
      .acc_count (acc_count)
   );

   function automatic logic [ADDR_W-1:0] blk(input int b, input int ofs);
      return ADDR_W'(b * 64 + ofs);
   endfunction

   // monitor: every accepted request is compared against the scoreboard
   always @(negedge clk) begin
      if (rst_n && acc_valid === 1'b1) begin
         n_checks++;
         if (sb_q.size() == 0) begin
            n_fails++;
            $display("FAIL unexpected accept: idx=%0d merged=%0d cnt=%0d expected none",
                     acc_idx, acc_merged, acc_count);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (int'(acc_idx) != e.idx || acc_merged !== e.merged || int'(acc_count) != e.cnt) begin
               n_fails++;
               $display("FAIL %s: got idx=%0d merged=%0d cnt=%0d expected idx=%0d merged=%0d cnt=%0d",
                        e.tag, acc_idx, acc_merged, acc_count, e.idx, e.merged, e.cnt);
            end
         end
      end
   end

   // one cycle of stimulus; called just after a rising edge
   task automatic cyc(input bit rv, input logic [ADDR_W-1:0] a, input logic [2:0] k,
                      input bit cv, input int ci,
                      input bit exp_acc, input int ei, input bit em, input int ec,
                      input string tag);
      req_valid = rv;
      req_addr  = a;
      req_kind  = k;
      cpl_valid = cv;
      cpl_idx   = IDX_W'(ci);
      if (rv && exp_acc) begin
         exp_t e;
         e.idx = ei; e.merged = em; e.cnt = ec; e.tag = tag;
         sb_q.push_back(e);
      end
      @(negedge clk);
      if (rv && !exp_acc) begin
         n_checks++;
         if (req_ready !== 1'b0) begin
            n_fails++;
            $display("FAIL %s: req_ready=%0b expected 0", tag, req_ready);
         end
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      cpl_valid = 1'b0;
   endtask

   task automatic req(input int b, input int ofs, input logic [2:0] k,
                      input int ei, input bit em, input int ec, input string tag);
      cyc(1'b1, blk(b, ofs), k, 1'b0, 0, 1'b1, ei, em, ec, tag);
   endtask

   task automatic stall(input int b, input logic [2:0] k, input string tag);
      cyc(1'b1, blk(b, 0), k, 1'b0, 0, 1'b0, 0, 1'b0, 0, tag);
   endtask

   task automatic cpl(input int ci);
      cyc(1'b0, '0, K_LD, 1'b1, ci, 1'b0, 0, 1'b0, 0, "cpl");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not finish, got hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (req_ready !== 1'b1 || acc_valid !== 1'b0) begin
         n_fails++;
         $display("FAIL R1 reset: ready=%0b acc_valid=%0b expected 1/0", req_ready, acc_valid);
      end
      @(posedge clk);
      #1;

      stall(1, 3'd6, "R5 reserved kind");
      req(1, 0,    K_LD, 0, 1'b0, 1, "R1 first alloc");
      req(1, 'h28, K_LD, 0, 1'b1, 2, "R2 low bits ignored");
      req(2, 0,    K_LD, 1, 1'b0, 1, "R2 other block");
      req(1, 0,    K_ST, 2, 1'b0, 1, "R3 store vs load entry");
      req(1, 8,    K_LD, 0, 1'b1, 3, "R11 lowest match");
      req(1, 8,    K_ST, 2, 1'b1, 2, "R4 store merges");
      req(3, 0,    K_ST, 3, 1'b0, 1, "R4 store alloc");
      req(3, 4,    K_LD, 3, 1'b1, 2, "R4 load into store");
      req(3, 16,   K_ST, 3, 1'b1, 3, "R4 kind kept store");
      req(4, 0,    K_STC, 4, 1'b0, 1, "R5 cond alloc");
      req(4, 0,    K_STC, 4, 1'b1, 2, "R5 cond merge");
      req(4, 0,    K_LD,  5, 1'b0, 1, "R5 load vs cond");
      req(4, 0,    K_WH,  6, 1'b0, 1, "R5 hint vs others");
      req(4, 0,    K_WH,  6, 1'b1, 2, "R5 hint merge");
      req(4, 0,    K_EV,  7, 1'b0, 1, "R5 evict alloc");
      stall(4, K_IF, "R7 full no match");
      req(4, 0,    K_EV,  7, 1'b1, 2, "R7 merge while full");
      cpl(5);
      req(4, 0,    K_IF,  5, 1'b0, 1, "R8 freed slot reused");
      cpl(1);
      req(2, 0,    K_LD,  1, 1'b0, 1, "R8 no merge after completion");
      cyc(1'b1, blk(3, 0), K_ST, 1'b1, 3, 1'b1, 3, 1'b0, 1, "R9 same-cycle cpl");
      for (int c = 2; c <= 7; c++)
         req(4, 0, K_IF, 5, 1'b1, c, "R10 count up");
      stall(4, K_IF, "R10 saturated entry");
      cpl(0);
      req(4, 0,    K_IF,  0, 1'b0, 1, "R10 alloc past saturated");
      req(4, 0,    K_IF,  0, 1'b1, 2, "R11 pick unsaturated lowest");
      cpl(6);
      cpl(2);
      req(9, 0,    K_WH,  2, 1'b0, 1, "R6 lowest free");
      req(9, 0,    K_ST,  6, 1'b0, 1, "R6 next free");

      repeat (2) @(posedge clk);
      n_checks++;
      if (sb_q.size() != 0) begin
         n_fails++;
         $display("FAIL scoreboard: %0d left expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule